// File: doc/BRIEF.md
# Execute-Only Region Filter for an AHB-Lite Program Memory

This block sits on the path between an AHB-Lite manager and the subordinate that holds program code. It marks one address range as execute-only. Instruction fetches into that range reach the memory as normal. Data reads and data writes into the range never reach the memory: the filter completes them by itself, returning zero for reads and discarding writes. Debugger traffic and vector-table reads are marked as data accesses, so they are refused like any other data access. Transfers outside the range, and all transfers while protection is off, pass through unchanged.

The window is set by an inclusive pair of bounds, a start address and an end address. After reset, protection is off so that firmware can be debugged. A configuration write can turn protection on and, in the same write, lock it. Once locked, the enable and both bounds stay frozen until the next reset. The filter checks each transfer in its address phase. It holds the memory's select low for a refused transfer and registers its decision. In the following data phase, it uses that decision to choose between the memory's response and its own zero response.

The data-phase steering is a two-state machine. `DP_PASS` routes the memory's read data, ready and response to the manager. `DP_BLOCK` drives zero data, ready high and an OKAY response. The state moves only when the bus ready is high. It takes the transition `to_block` when the transfer just accepted was refused, and `to_pass` for any other accepted transfer, including idle cycles. While ready is low, the state holds.

Top module: `xom_filter`

## Requirements
- R1: A NONSEQ or SEQ transfer with `hprot[0]`=0 (instruction fetch) is forwarded: `mem_hsel` equals `hsel_in`, and its data phase returns the memory's data and ready.
- R2: While protection is on, a NONSEQ or SEQ transfer with `hprot[0]`=1 (data access) whose address satisfies start <= `haddr` <= end is refused. `mem_hsel` is low in its address phase, and the bounds are inclusive.
- R3: The data phase of a refused transfer lasts one cycle, with `hrdata`=0, `hreadyout`=1 and `hresp`=0 (OKAY).
- R4: A refused data write causes no write access at the memory.
- R5: A data access whose address lies outside the window is forwarded and completes with the memory's data.
- R6: IDLE (`htrans`=2'b00) and BUSY (`htrans`=2'b01) transfers are always forwarded, whatever their address or `hprot[0]`.
- R7: After reset, protection is off and every transfer is forwarded unchanged, including data accesses to any address.
- R8: A configuration write that sets `cfg_lock` together with `cfg_enable` locks the filter. Once locked, further configuration writes have no effect on the enable or the bounds, and only reset releases the lock. `cfg_lock` written with `cfg_enable`=0 does not lock.
- R9: The decision is registered only when `hready`=1. While the memory stalls a forwarded transfer, the manager sees the memory's ready and data, and the refused transfer queued behind it still completes with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Protection enable value to write |
| cfg_lock | input | 1 | Lock value to write (taken only with enable) |
| cfg_base | input | AW | Inclusive window start to write |
| cfg_limit | input | AW | Inclusive window end to write |
| hsel_in | input | 1 | Select from the address decoder |
| haddr | input | AW | Transfer address |
| htrans | input | 2 | Transfer type |
| hprot | input | 4 | Protection attributes; bit 0 = 1 marks a data access |
| hready | input | 1 | Bus ready (end of previous data phase) |
| mem_hsel | output | 1 | Gated select toward the memory |
| mem_hrdata | input | DW | Read data from the memory |
| mem_hreadyout | input | 1 | Ready from the memory |
| mem_hresp | input | 1 | Response from the memory |
| hrdata | output | DW | Read data toward the manager |
| hreadyout | output | 1 | Ready toward the manager |
| hresp | output | 1 | Response toward the manager |

## Verification
A vector table crosses fetch and data accesses with addresses just below, at, inside, at the end of and just past the window. This separates a correct inclusive comparison from an off-by-one, and the fetch bit from the address test. Reads, writes, SEQ transfers and idle cycles are run back to back, so a decision that is not registered with its own transfer shows up as data attached to the wrong phase. Directed sequences cover three further cases. A memory stall ahead of a refused transfer tests whether the held state waits for ready. A lock followed by a disabling write tests whether the freeze holds. A lock written without enable tests that it does not freeze the configuration.

// File: rtl/xom_pkg.sv
package xom_pkg;

    // Data-phase steering state: who answers the manager this cycle.
    typedef enum logic [0:0] {
        DP_PASS  = 1'b0,
        DP_BLOCK = 1'b1
    } dphase_e;

    // Bit positions within the AHB transfer attributes.
    localparam int unsigned TRANS_ACTIVE_BIT = 1;
    localparam int unsigned PROT_DATA_BIT    = 0;

endpackage

// File: rtl/xom_cfg_regs.sv
module xom_cfg_regs #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_enable,
    input  logic          wr_lock,
    input  logic [AW-1:0] wr_lo,
    input  logic [AW-1:0] wr_hi,
    output logic          prot_on,
    output logic          locked,
    output logic [AW-1:0] lo_q,
    output logic [AW-1:0] hi_q
);

    // Register file frozen once the lock bit is set; reset is the only release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_on <= 1'b0;
            locked  <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (wr_stb && !locked) begin
            prot_on <= wr_enable;
            locked  <= wr_lock && wr_enable;
            lo_q    <= wr_lo;
            hi_q    <= wr_hi;
        end
    end

endmodule

// File: rtl/xom_window_cmp.sv
module xom_window_cmp
    import xom_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          prot_on,
    input  logic [AW-1:0] lo_q,
    input  logic [AW-1:0] hi_q,
    input  logic          hsel_in,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic [3:0]    hprot,
    output logic          refuse
);

    logic in_range;
    logic is_data;
    logic is_active;

    // Inclusive bounds on both ends.
    assign in_range  = (haddr >= lo_q) && (haddr <= hi_q);
    assign is_data   = hprot[PROT_DATA_BIT];
    assign is_active = htrans[TRANS_ACTIVE_BIT];

    assign refuse = prot_on && hsel_in && is_active && is_data && in_range;

endmodule

// File: rtl/xom_dphase_fsm.sv
module xom_dphase_fsm
    import xom_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          refuse,
    input  logic [DW-1:0] mem_hrdata,
    input  logic          mem_hreadyout,
    input  logic          mem_hresp,
    output logic [DW-1:0] hrdata,
    output logic          hreadyout,
    output logic          hresp,
    output dphase_e       state
);

    dphase_e state_nx;

    // Transitions: to_block on an accepted refused transfer, to_pass on any
    // other accepted transfer; hold while the bus is stalled.
    always_comb begin
        state_nx = state;
        if (hready) begin
            state_nx = refuse ? DP_BLOCK : DP_PASS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DP_PASS;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            DP_PASS: begin
                hrdata    = mem_hrdata;
                hreadyout = mem_hreadyout;
                hresp     = mem_hresp;
            end
            DP_BLOCK: begin
                hrdata    = '0;
                hreadyout = 1'b1;
                hresp     = 1'b0;
            end
            default: begin
                hrdata    = '0;
                hreadyout = 1'b1;
                hresp     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xom_filter.sv
module xom_filter
    import xom_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_enable,
    input  logic          cfg_lock,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic          hsel_in,
    input  logic [AW-1:0] haddr,
    input  logic [1:0]    htrans,
    input  logic [3:0]    hprot,
    input  logic          hready,
    output logic          mem_hsel,
    input  logic [DW-1:0] mem_hrdata,
    input  logic          mem_hreadyout,
    input  logic          mem_hresp,
    output logic [DW-1:0] hrdata,
    output logic          hreadyout,
    output logic          hresp
);

    logic          prot_on;
    logic          locked;
    logic [AW-1:0] lo_q;
    logic [AW-1:0] hi_q;
    logic          refuse;
    dphase_e       state;

    xom_cfg_regs #(.AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (cfg_we),
        .wr_enable (cfg_enable),
        .wr_lock   (cfg_lock),
        .wr_lo     (cfg_base),
        .wr_hi     (cfg_limit),
        .prot_on   (prot_on),
        .locked    (locked),
        .lo_q      (lo_q),
        .hi_q      (hi_q)
    );

    xom_window_cmp #(.AW(AW)) u_cmp (
        .prot_on (prot_on),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .hsel_in (hsel_in),
        .haddr   (haddr),
        .htrans  (htrans),
        .hprot   (hprot),
        .refuse  (refuse)
    );

    xom_dphase_fsm #(.DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hready        (hready),
        .refuse        (refuse),
        .mem_hrdata    (mem_hrdata),
        .mem_hreadyout (mem_hreadyout),
        .mem_hresp     (mem_hresp),
        .hrdata        (hrdata),
        .hreadyout     (hreadyout),
        .hresp         (hresp),
        .state         (state)
    );

    // Refused transfers never reach the memory.
    assign mem_hsel = hsel_in && !refuse;

endmodule

// File: rtl/xom_filter_chk.sv
module xom_filter_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsel_in,
    input logic [1:0]    htrans,
    input logic [3:0]    hprot,
    input logic          hready,
    input logic          mem_hsel,
    input logic [DW-1:0] mem_hrdata,
    input logic          mem_hreadyout,
    input logic [DW-1:0] hrdata,
    input logic          hreadyout,
    input logic          hresp,
    input logic          prot_on,
    input logic          locked
);

    p_fetch_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel_in && htrans[1] && !hprot[0]) |-> mem_hsel);

    p_blk_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hready && hsel_in && htrans[1] && !mem_hsel)
            |-> (hrdata == '0) && hreadyout && !hresp);

    p_idle_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!htrans[1]) |-> (mem_hsel == hsel_in));

    p_off_transparent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_on) |-> (mem_hsel == hsel_in));

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && prot_on));

    p_pass_steer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hready && mem_hsel && htrans[1])
            |-> (hrdata == mem_hrdata) && (hreadyout == mem_hreadyout));

endmodule

bind xom_filter xom_filter_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hsel_in       (hsel_in),
    .htrans        (htrans),
    .hprot         (hprot),
    .hready        (hready),
    .mem_hsel      (mem_hsel),
    .mem_hrdata    (mem_hrdata),
    .mem_hreadyout (mem_hreadyout),
    .hrdata        (hrdata),
    .hreadyout     (hreadyout),
    .hresp         (hresp),
    .prot_on       (prot_on),
    .locked        (locked)
);

// File: tb/tb_xom_filter.sv
module tb_xom_filter;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam logic [31:0] PAT = 32'hC0DE_0000;

    typedef struct packed {
        logic [31:0] a;
        logic        d;
        logic        w;
        logic [1:0]  t;
        logic        b;
    } vec_t;

    localparam int NV = 10;
    // addr, data-access, write, htrans, expect refused
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 1'b0, 1'b0, 2'b10, 1'b0},  // R1 fetch at start
        '{32'h0000_1000, 1'b1, 1'b0, 2'b10, 1'b1},  // R2 data at start
        '{32'h0000_1FFF, 1'b1, 1'b0, 2'b10, 1'b1},  // R2 data at end
        '{32'h0000_0FFF, 1'b1, 1'b0, 2'b10, 1'b0},  // R5 just below
        '{32'h0000_2000, 1'b1, 1'b0, 2'b10, 1'b0},  // R5 just past
        '{32'h0000_1800, 1'b1, 1'b1, 2'b10, 1'b1},  // R4 write inside
        '{32'h0000_3000, 1'b1, 1'b1, 2'b10, 1'b0},  // R5 write outside
        '{32'h0000_1FFC, 1'b0, 1'b0, 2'b11, 1'b0},  // R1 SEQ fetch
        '{32'h0000_1800, 1'b1, 1'b0, 2'b00, 1'b0},  // R6 idle inside
        '{32'h0000_1804, 1'b1, 1'b0, 2'b11, 1'b1}   // R2 SEQ data
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_lock = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic          hsel_in = 1'b1;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic [3:0]    hprot = 4'b0000;
    logic          hwrite = 1'b0;
    logic          hready;
    logic          mem_hsel;
    logic [DW-1:0] mem_hrdata;
    logic          mem_hreadyout;
    logic          mem_hresp = 1'b0;
    logic [DW-1:0] hrdata;
    logic          hreadyout;
    logic          hresp;

    logic mem_rdy = 1'b1;
    logic mem_active;
    int   mem_writes;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    assign hready = hreadyout;

    xom_filter #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .hsel_in(hsel_in), .haddr(haddr), .htrans(htrans), .hprot(hprot),
        .hready(hready), .mem_hsel(mem_hsel), .mem_hrdata(mem_hrdata),
        .mem_hreadyout(mem_hreadyout), .mem_hresp(mem_hresp),
        .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    // Simple memory model: read data is a function of the address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_active <= 1'b0;
            mem_hrdata <= '0;
            mem_writes <= 0;
        end else if (hready) begin
            mem_active <= mem_hsel && htrans[1];
            if (mem_hsel && htrans[1]) begin
                if (hwrite) mem_writes <= mem_writes + 1;
                else        mem_hrdata <= haddr ^ PAT;
            end
        end
    end
    assign mem_hreadyout = mem_active ? mem_rdy : 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        htrans = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg(input logic en, input logic lk, input logic [31:0] lo,
                       input logic [31:0] hi);
        cfg_we = 1'b1; cfg_enable = en; cfg_lock = lk; cfg_base = lo; cfg_limit = hi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [31:0] a, input logic d, input logic w,
                         input logic [1:0] t);
        haddr = a; hprot = {3'b000, d}; hwrite = w; htrans = t;
    endtask

    // One data read with an idle cycle after it; returns select and data.
    task automatic rd(input logic [31:0] a, output logic sel, output logic [31:0] dat);
        drive(a, 1'b1, 1'b0, 2'b10);
        #1 sel = mem_hsel;
        @(negedge clk);
        drive(32'h0, 1'b0, 1'b0, 2'b00);
        #1 dat = hrdata;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic        sel;
        logic [31:0] dat;
        int          w0;

        do_reset();
        // Reset state
        check(hreadyout === 1'b1, "R3 reset hreadyout", {31'b0, hreadyout}, 32'd1);
        check(hresp === 1'b0, "R3 reset hresp", {31'b0, hresp}, 32'd0);

        // R7: off after reset, data access to any address forwarded
        rd(32'h0000_1800, sel, dat);
        check(sel === 1'b1, "R7 off select", {31'b0, sel}, 32'd1);
        check(dat === (32'h0000_1800 ^ PAT), "R7 off data", dat, 32'h0000_1800 ^ PAT);

        // Vector table walk, pipelined back to back
        cfg(1'b1, 1'b0, 32'h0000_1000, 32'h0000_1FFF);
        w0 = mem_writes;
        drive(VECS[0].a, VECS[0].d, VECS[0].w, VECS[0].t);
        #1 check(mem_hsel === !VECS[0].b, "R1/R2 select v0", {31'b0, mem_hsel}, {31'b0, !VECS[0].b});
        for (int i = 1; i <= NV; i++) begin
            @(negedge clk);
            #1;
            if (VECS[i-1].t[1] && !VECS[i-1].w) begin
                logic [31:0] e;
                e = VECS[i-1].b ? 32'h0 : (VECS[i-1].a ^ PAT);
                check(hrdata === e, VECS[i-1].b ? "R3 refused data" : "R1/R5 forwarded data", hrdata, e);
            end
            check(hreadyout === 1'b1 && hresp === 1'b0, "R3 ready/okay", {30'b0, hreadyout, hresp}, 32'd2);
            if (i < NV) begin
                drive(VECS[i].a, VECS[i].d, VECS[i].w, VECS[i].t);
                #1 check(mem_hsel === !VECS[i].b, "R2/R5/R6 select", {31'b0, mem_hsel}, {31'b0, !VECS[i].b});
            end else begin
                drive(32'h0, 1'b0, 1'b0, 2'b00);
            end
        end
        @(negedge clk);
        check(mem_writes - w0 == 1, "R4 only outside write reached memory", mem_writes - w0, 32'd1);

        // R9: memory stall ahead of a refused transfer
        mem_rdy = 1'b0;
        drive(32'h0000_3000, 1'b1, 1'b0, 2'b10);
        @(negedge clk);
        #1 check(hreadyout === 1'b0, "R9 stall seen", {31'b0, hreadyout}, 32'd0);
        drive(32'h0000_1800, 1'b1, 1'b0, 2'b10);
        @(negedge clk);
        #1 check(hreadyout === 1'b0, "R9 stall held", {31'b0, hreadyout}, 32'd0);
        mem_rdy = 1'b1;
        #1 check(hreadyout === 1'b1 && hrdata === (32'h0000_3000 ^ PAT), "R9 stalled data", hrdata, 32'h0000_3000 ^ PAT);
        @(negedge clk);
        drive(32'h0, 1'b0, 1'b0, 2'b00);
        #1 check(hrdata === 32'h0 && hreadyout === 1'b1, "R9 refused after stall", hrdata, 32'h0);
        @(negedge clk);

        // R8: lock, then attempt to disable and move the window
        cfg(1'b1, 1'b1, 32'h0000_1000, 32'h0000_1FFF);
        cfg(1'b0, 1'b0, 32'h0000_8000, 32'h0000_8FFF);
        rd(32'h0000_1800, sel, dat);
        check(sel === 1'b0 && dat === 32'h0, "R8 locked still refuses", dat, 32'h0);
        rd(32'h0000_8000, sel, dat);
        check(sel === 1'b1, "R8 locked window unchanged", {31'b0, sel}, 32'd1);

        // R8: reset releases the lock
        do_reset();
        rd(32'h0000_1800, sel, dat);
        check(sel === 1'b1 && dat === (32'h0000_1800 ^ PAT), "R8 reset releases", dat, 32'h0000_1800 ^ PAT);

        // R8: lock without enable does not freeze
        cfg(1'b0, 1'b1, 32'h0, 32'h0);
        cfg(1'b1, 1'b0, 32'h0000_1000, 32'h0000_1FFF);
        rd(32'h0000_1800, sel, dat);
        check(sel === 1'b0 && dat === 32'h0, "R8 lock needs enable", dat, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule